// File: doc/BRIEF.md
# External Register Field Responder

This block is the hardware agent behind a 32-bit register that the register bank leaves to outside logic. The register is replicated `NUM_INST` times. Each copy is split into a low and a high field of `FIELD_W` bits. A second, narrower view of each copy (the alias view) reaches only the low field. The bus-side bridge raises level-held request wires per field and direction. This block stores the field values in flops, answers every request with an acknowledge held until the request drops, and can flag an error for any access.

Writes carry a per-bit mask, and only masked bits change. Reads return the whole field. An alias access arrives on its own request, data and mask wires but is answered on the main register's acknowledge and error wires. Because the bridge completes an access only when both field acknowledges are high, an alias access raises the acknowledge of both fields. The acknowledge appears a programmable 0 to 3 extra cycles after a request is first seen. A per-instance error enable turns the next acknowledged access into an errored one.

Top module: `xreg_responder`

## Requirements
- R1: When a request is first sampled high at a rising edge and the instance is idle, the matching acknowledge is high after the `lat_cfg`-th following edge. So it is first observable `lat_cfg`+1 edges after the request was driven (0 to 3 extra cycles).
- R2: An acknowledge stays high while its request is held. It drops at the first edge at which the request is sampled low, together with its error.
- R3: If `err_en[i]` is 1 at the edge where an access of instance i is acknowledged, the error wire for that direction and field rises with the acknowledge and stays high exactly as long as it. Otherwise that error wire stays 0.
- R4: A write acknowledged without error updates only the bits whose mask bit is 1. Bit k of a mask guards bit k of the field, and the other bits keep their value.
- R5: A write acknowledged with an error leaves both stored fields unchanged.
- R6: The read-data outputs always present the full stored field of every instance, whatever mask is driven.
- R7: An alias write updates only the low field, using the alias data and mask. An alias read returns data on the low read-data bus. For either, the acknowledge and error of both the low and the high field of that direction are raised.
- R8: Only one access per instance is serviced at a time. When several requests are pending, the order is main write, main read, alias write, alias read. A deferred request is taken once the current acknowledge has fallen.
- R9: A synchronous active-high reset clears every stored field and drives all acknowledge and error outputs low.
- R10: Instances are independent. Instance i uses bit i of every per-instance 1-bit bus and bits [FIELD_W·i+FIELD_W-1 : FIELD_W·i] of every data or mask bus.
- R11: A request that drops before being acknowledged gets no acknowledge and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lat_cfg | input | LAT_W | Extra acknowledge delay in cycles |
| err_en | input | NUM_INST | Per-instance error enable |
| mlo_wr_req | input | NUM_INST | Main low-field write request |
| mlo_rd_req | input | NUM_INST | Main low-field read request |
| mlo_wdata | input | NUM_INST·FIELD_W | Main low-field write data |
| mlo_wmask | input | NUM_INST·FIELD_W | Main low-field write mask |
| mhi_wr_req | input | NUM_INST | Main high-field write request |
| mhi_rd_req | input | NUM_INST | Main high-field read request |
| mhi_wdata | input | NUM_INST·FIELD_W | Main high-field write data |
| mhi_wmask | input | NUM_INST·FIELD_W | Main high-field write mask |
| als_wr_req | input | NUM_INST | Alias write request |
| als_rd_req | input | NUM_INST | Alias read request |
| als_wdata | input | NUM_INST·FIELD_W | Alias write data (low field) |
| als_wmask | input | NUM_INST·FIELD_W | Alias write mask (low field) |
| lo_wr_ack | output | NUM_INST | Low-field write acknowledge |
| lo_rd_ack | output | NUM_INST | Low-field read acknowledge |
| lo_wr_err | output | NUM_INST | Low-field write error |
| lo_rd_err | output | NUM_INST | Low-field read error |
| lo_rdata | output | NUM_INST·FIELD_W | Low-field stored value |
| hi_wr_ack | output | NUM_INST | High-field write acknowledge |
| hi_rd_ack | output | NUM_INST | High-field read acknowledge |
| hi_wr_err | output | NUM_INST | High-field write error |
| hi_rd_err | output | NUM_INST | High-field read error |
| hi_rdata | output | NUM_INST·FIELD_W | High-field stored value |

## Verification
Writes are tried with full masks, with byte-lane masks and with one field only. This separates correct bit guarding from whole-field overwrites and from leakage into the unrequested field. Reads at each latency setting tell the delay counter apart from an off-by-one. Errored writes show that an error suppresses the update. Simultaneous main and alias writes with different masks reveal the service order in the final low-field value. A request dropped mid-wait and two instances driven at once check that no ghost acknowledge or cross-instance write occurs.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

  // Access source, in service priority order
  typedef enum logic [1:0] {
    SRC_MAIN_WR = 2'd0,
    SRC_MAIN_RD = 2'd1,
    SRC_ALS_WR  = 2'd2,
    SRC_ALS_RD  = 2'd3
  } xreg_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } xreg_state_e;

endpackage

// File: rtl/xreg_field.sv
module xreg_field #(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [FIELD_W-1:0] wdata,
  input  logic [FIELD_W-1:0] wmask,
  output logic [FIELD_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= (q & ~wmask) | (wdata & wmask);
    end
  end

  // R4
  masked_bits_keep_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (((q ^ $past(q)) & ~$past(wmask)) == '0));

  // R5
  no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/xreg_lane_engine.sv
module xreg_lane_engine
  import xreg_pkg::*;
#(
  parameter int LAT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             err_en_i,
  input  logic             mw_lo_i,
  input  logic             mw_hi_i,
  input  logic             mr_lo_i,
  input  logic             mr_hi_i,
  input  logic             aw_i,
  input  logic             ar_i,
  output logic             lo_wr_ack_o,
  output logic             hi_wr_ack_o,
  output logic             lo_rd_ack_o,
  output logic             hi_rd_ack_o,
  output logic             lo_wr_err_o,
  output logic             hi_wr_err_o,
  output logic             lo_rd_err_o,
  output logic             hi_rd_err_o,
  output logic             wr_lo_o,
  output logic             wr_hi_o,
  output logic             alias_sel_o
);

  localparam logic [LAT_W-1:0] LAT_ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  xreg_state_e      st_q;
  xreg_src_e        src_q, pick_src, src_now;
  logic             lop_q, hip_q, ack_q, err_q;
  logic [LAT_W-1:0] cnt_q;
  logic             pick_vld, pick_lo, pick_hi;
  logic             lo_now, hi_now, active, enter_ack, is_wr, is_rd;

  // Priority pick among pending requests
  always_comb begin
    pick_vld = 1'b1;
    pick_src = SRC_MAIN_WR;
    pick_lo  = mw_lo_i;
    pick_hi  = mw_hi_i;
    if (mw_lo_i || mw_hi_i) begin
      pick_src = SRC_MAIN_WR;
    end else if (mr_lo_i || mr_hi_i) begin
      pick_src = SRC_MAIN_RD;
      pick_lo  = mr_lo_i;
      pick_hi  = mr_hi_i;
    end else if (aw_i) begin
      pick_src = SRC_ALS_WR;
      pick_lo  = 1'b1;
      pick_hi  = 1'b1;
    end else if (ar_i) begin
      pick_src = SRC_ALS_RD;
      pick_lo  = 1'b1;
      pick_hi  = 1'b1;
    end else begin
      pick_vld = 1'b0;
    end
  end

  // Is the request of the access in service still held
  always_comb begin
    case (src_q)
      SRC_MAIN_WR: active = mw_lo_i || mw_hi_i;
      SRC_MAIN_RD: active = mr_lo_i || mr_hi_i;
      SRC_ALS_WR:  active = aw_i;
      default:     active = ar_i;
    endcase
  end

  assign src_now   = (st_q == ST_IDLE) ? pick_src : src_q;
  assign lo_now    = (st_q == ST_IDLE) ? pick_lo  : lop_q;
  assign hi_now    = (st_q == ST_IDLE) ? pick_hi  : hip_q;
  assign enter_ack = ((st_q == ST_IDLE) && pick_vld && (lat_i == '0)) ||
                     ((st_q == ST_WAIT) && active && (cnt_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      src_q <= SRC_MAIN_WR;
      lop_q <= 1'b0;
      hip_q <= 1'b0;
      ack_q <= 1'b0;
      err_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (pick_vld) begin
            src_q <= pick_src;
            lop_q <= pick_lo;
            hip_q <= pick_hi;
            if (lat_i == '0) begin
              st_q  <= ST_ACK;
              ack_q <= 1'b1;
              err_q <= err_en_i;
            end else begin
              st_q  <= ST_WAIT;
              cnt_q <= lat_i - LAT_ONE;
            end
          end
        end
        ST_WAIT: begin
          if (!active) begin
            st_q <= ST_IDLE;
          end else if (cnt_q == '0) begin
            st_q  <= ST_ACK;
            ack_q <= 1'b1;
            err_q <= err_en_i;
          end else begin
            cnt_q <= cnt_q - LAT_ONE;
          end
        end
        ST_ACK: begin
          if (!active) begin
            st_q  <= ST_IDLE;
            ack_q <= 1'b0;
            err_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign is_wr = (src_q == SRC_MAIN_WR) || (src_q == SRC_ALS_WR);
  assign is_rd = !is_wr;

  assign lo_wr_ack_o = ack_q && is_wr && (lop_q || (src_q == SRC_ALS_WR));
  assign hi_wr_ack_o = ack_q && is_wr && (hip_q || (src_q == SRC_ALS_WR));
  assign lo_rd_ack_o = ack_q && is_rd && (lop_q || (src_q == SRC_ALS_RD));
  assign hi_rd_ack_o = ack_q && is_rd && (hip_q || (src_q == SRC_ALS_RD));
  assign lo_wr_err_o = err_q && lo_wr_ack_o;
  assign hi_wr_err_o = err_q && hi_wr_ack_o;
  assign lo_rd_err_o = err_q && lo_rd_ack_o;
  assign hi_rd_err_o = err_q && hi_rd_ack_o;

  // Field write strobes for the edge that raises acknowledge
  assign wr_lo_o     = enter_ack && !err_en_i &&
                       (((src_now == SRC_MAIN_WR) && lo_now) || (src_now == SRC_ALS_WR));
  assign wr_hi_o     = enter_ack && !err_en_i && (src_now == SRC_MAIN_WR) && hi_now;
  assign alias_sel_o = (src_now == SRC_ALS_WR);

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_q && active) |=> ack_q);

  // R2
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !active) |=> (!ack_q && !err_q));

  // R3
  err_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ack_q);

  // R8
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lo_wr_ack_o || hi_wr_ack_o, lo_rd_ack_o || hi_rd_ack_o}));

  // R11
  abort_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_WAIT) && !active) |=> !ack_q);

endmodule

// File: rtl/xreg_responder.sv
module xreg_responder #(
  parameter int NUM_INST = 4,
  parameter int FIELD_W  = 16,
  parameter int LAT_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LAT_W-1:0]            lat_cfg,
  input  logic [NUM_INST-1:0]         err_en,
  input  logic [NUM_INST-1:0]         mlo_wr_req,
  input  logic [NUM_INST-1:0]         mlo_rd_req,
  input  logic [NUM_INST*FIELD_W-1:0] mlo_wdata,
  input  logic [NUM_INST*FIELD_W-1:0] mlo_wmask,
  input  logic [NUM_INST-1:0]         mhi_wr_req,
  input  logic [NUM_INST-1:0]         mhi_rd_req,
  input  logic [NUM_INST*FIELD_W-1:0] mhi_wdata,
  input  logic [NUM_INST*FIELD_W-1:0] mhi_wmask,
  input  logic [NUM_INST-1:0]         als_wr_req,
  input  logic [NUM_INST-1:0]         als_rd_req,
  input  logic [NUM_INST*FIELD_W-1:0] als_wdata,
  input  logic [NUM_INST*FIELD_W-1:0] als_wmask,
  output logic [NUM_INST-1:0]         lo_wr_ack,
  output logic [NUM_INST-1:0]         lo_rd_ack,
  output logic [NUM_INST-1:0]         lo_wr_err,
  output logic [NUM_INST-1:0]         lo_rd_err,
  output logic [NUM_INST*FIELD_W-1:0] lo_rdata,
  output logic [NUM_INST-1:0]         hi_wr_ack,
  output logic [NUM_INST-1:0]         hi_rd_ack,
  output logic [NUM_INST-1:0]         hi_wr_err,
  output logic [NUM_INST-1:0]         hi_rd_err,
  output logic [NUM_INST*FIELD_W-1:0] hi_rdata
);

  for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_inst
    localparam int LSB = gi * FIELD_W;

    logic               wr_lo, wr_hi, alias_sel;
    logic [FIELD_W-1:0] lo_d, lo_m;

    xreg_lane_engine #(.LAT_W(LAT_W)) u_engine (
      .clk         (clk),
      .rst         (rst),
      .lat_i       (lat_cfg),
      .err_en_i    (err_en[gi]),
      .mw_lo_i     (mlo_wr_req[gi]),
      .mw_hi_i     (mhi_wr_req[gi]),
      .mr_lo_i     (mlo_rd_req[gi]),
      .mr_hi_i     (mhi_rd_req[gi]),
      .aw_i        (als_wr_req[gi]),
      .ar_i        (als_rd_req[gi]),
      .lo_wr_ack_o (lo_wr_ack[gi]),
      .hi_wr_ack_o (hi_wr_ack[gi]),
      .lo_rd_ack_o (lo_rd_ack[gi]),
      .hi_rd_ack_o (hi_rd_ack[gi]),
      .lo_wr_err_o (lo_wr_err[gi]),
      .hi_wr_err_o (hi_wr_err[gi]),
      .lo_rd_err_o (lo_rd_err[gi]),
      .hi_rd_err_o (hi_rd_err[gi]),
      .wr_lo_o     (wr_lo),
      .wr_hi_o     (wr_hi),
      .alias_sel_o (alias_sel)
    );

    // Low field takes data from either the main or the alias view
    assign lo_d = alias_sel ? als_wdata[LSB +: FIELD_W] : mlo_wdata[LSB +: FIELD_W];
    assign lo_m = alias_sel ? als_wmask[LSB +: FIELD_W] : mlo_wmask[LSB +: FIELD_W];

    xreg_field #(.FIELD_W(FIELD_W)) u_lo (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_lo),
      .wdata (lo_d),
      .wmask (lo_m),
      .q     (lo_rdata[LSB +: FIELD_W])
    );

    xreg_field #(.FIELD_W(FIELD_W)) u_hi (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_hi),
      .wdata (mhi_wdata[LSB +: FIELD_W]),
      .wmask (mhi_wmask[LSB +: FIELD_W]),
      .q     (hi_rdata[LSB +: FIELD_W])
    );
  end

endmodule

// File: tb/test_xreg_responder.sv
`timescale 1ns/1ps
module test_xreg_responder;

  localparam int N  = 4;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]      lat_cfg = '0;
  logic [N-1:0]    err_en = '0;
  logic [N-1:0]    mlo_wr_req = '0, mlo_rd_req = '0, mhi_wr_req = '0, mhi_rd_req = '0;
  logic [N-1:0]    als_wr_req = '0, als_rd_req = '0;
  logic [N*FW-1:0] mlo_wdata = '0, mlo_wmask = '0, mhi_wdata = '0, mhi_wmask = '0;
  logic [N*FW-1:0] als_wdata = '0, als_wmask = '0;
  logic [N-1:0]    lo_wr_ack, lo_rd_ack, lo_wr_err, lo_rd_err;
  logic [N-1:0]    hi_wr_ack, hi_rd_ack, hi_wr_err, hi_rd_err;
  logic [N*FW-1:0] lo_rdata, hi_rdata;

  always #5 clk = ~clk;

  xreg_responder #(.NUM_INST(N), .FIELD_W(FW), .LAT_W(2)) i_xreg_responder (
    .clk(clk), .rst(rst), .lat_cfg(lat_cfg), .err_en(err_en),
    .mlo_wr_req(mlo_wr_req), .mlo_rd_req(mlo_rd_req), .mlo_wdata(mlo_wdata), .mlo_wmask(mlo_wmask),
    .mhi_wr_req(mhi_wr_req), .mhi_rd_req(mhi_rd_req), .mhi_wdata(mhi_wdata), .mhi_wmask(mhi_wmask),
    .als_wr_req(als_wr_req), .als_rd_req(als_rd_req), .als_wdata(als_wdata), .als_wmask(als_wmask),
    .lo_wr_ack(lo_wr_ack), .lo_rd_ack(lo_rd_ack), .lo_wr_err(lo_wr_err), .lo_rd_err(lo_rd_err),
    .lo_rdata(lo_rdata),
    .hi_wr_ack(hi_wr_ack), .hi_rd_ack(hi_rd_ack), .hi_wr_err(hi_wr_err), .hi_rd_err(hi_rd_err),
    .hi_rdata(hi_rdata)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // state: 0 idle, 1 waiting, 2 acknowledging; src: 0 main wr, 1 main rd, 2 alias wr, 3 alias rd
  int          m_st[N], m_cnt[N], m_src[N];
  bit          m_lop[N], m_hip[N], m_ack[N], m_err[N];
  logic [15:0] m_lo[N], m_hi[N];

  function automatic bit req_live(input int i, input int s);
    case (s)
      0: return mlo_wr_req[i] | mhi_wr_req[i];
      1: return mlo_rd_req[i] | mhi_rd_req[i];
      2: return als_wr_req[i];
      default: return als_rd_req[i];
    endcase
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [15:0] m);
    return (old & ~m) | (d & m);
  endfunction

  task automatic m_enter(input int i);
    m_st[i]  = 2;
    m_ack[i] = 1'b1;
    m_err[i] = err_en[i];
    if (!err_en[i]) begin
      if (m_src[i] == 0) begin
        if (m_lop[i]) m_lo[i] = merge(m_lo[i], mlo_wdata[i*FW +: FW], mlo_wmask[i*FW +: FW]);
        if (m_hip[i]) m_hi[i] = merge(m_hi[i], mhi_wdata[i*FW +: FW], mhi_wmask[i*FW +: FW]);
      end else if (m_src[i] == 2) begin
        m_lo[i] = merge(m_lo[i], als_wdata[i*FW +: FW], als_wmask[i*FW +: FW]);
      end
    end
  endtask

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      bit pv, pl, ph, act;
      int ps;
      if (rst) begin
        m_st[i] = 0; m_cnt[i] = 0; m_src[i] = 0; m_lop[i] = 0; m_hip[i] = 0;
        m_ack[i] = 0; m_err[i] = 0; m_lo[i] = '0; m_hi[i] = '0;
      end else begin
        pv = 1; ps = 0; pl = 0; ph = 0;
        if (mlo_wr_req[i] | mhi_wr_req[i]) begin ps = 0; pl = mlo_wr_req[i]; ph = mhi_wr_req[i]; end
        else if (mlo_rd_req[i] | mhi_rd_req[i]) begin ps = 1; pl = mlo_rd_req[i]; ph = mhi_rd_req[i]; end
        else if (als_wr_req[i]) begin ps = 2; pl = 1; ph = 1; end
        else if (als_rd_req[i]) begin ps = 3; pl = 1; ph = 1; end
        else pv = 0;
        act = req_live(i, m_src[i]);
        case (m_st[i])
          0: if (pv) begin
               m_src[i] = ps; m_lop[i] = pl; m_hip[i] = ph;
               if (lat_cfg == 0) m_enter(i);
               else begin m_st[i] = 1; m_cnt[i] = int'(lat_cfg) - 1; end
             end
          1: if (!act) m_st[i] = 0;
             else if (m_cnt[i] == 0) m_enter(i);
             else m_cnt[i] = m_cnt[i] - 1;
          default: if (!act) begin m_st[i] = 0; m_ack[i] = 0; m_err[i] = 0; end
        endcase
      end
    end
  end

  // expected {lo_wr, hi_wr, lo_rd, hi_rd}
  function automatic logic [3:0] exp_ack(input int i);
    bit wr, al;
    wr = (m_src[i] == 0) || (m_src[i] == 2);
    al = (m_src[i] >= 2);
    if (!m_ack[i]) return 4'b0;
    return {wr & (m_lop[i] | al), wr & (m_hip[i] | al), !wr & (m_lop[i] | al), !wr & (m_hip[i] | al)};
  endfunction

  // per-cycle comparison away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      for (int i = 0; i < N; i++) begin
        logic [3:0] ea;
        ea = exp_ack(i);
        check($sformatf("R1 R2 ack inst%0d", i),
              {28'd0, lo_wr_ack[i], hi_wr_ack[i], lo_rd_ack[i], hi_rd_ack[i]}, {28'd0, ea});
        check($sformatf("R3 err inst%0d", i),
              {28'd0, lo_wr_err[i], hi_wr_err[i], lo_rd_err[i], hi_rd_err[i]},
              {28'd0, m_err[i] ? ea : 4'b0});
        check($sformatf("R6 rdata inst%0d", i),
              {lo_rdata[i*FW +: FW], hi_rdata[i*FW +: FW]}, {m_lo[i], m_hi[i]});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_req(input int i, input int kind, input bit ulo, input bit uhi, input bit val,
                         input logic [15:0] dlo, input logic [15:0] mlo,
                         input logic [15:0] dhi, input logic [15:0] mhi);
    case (kind)
      0: begin
        if (ulo) begin mlo_wr_req[i] = val; mlo_wdata[i*FW +: FW] = dlo; mlo_wmask[i*FW +: FW] = mlo; end
        if (uhi) begin mhi_wr_req[i] = val; mhi_wdata[i*FW +: FW] = dhi; mhi_wmask[i*FW +: FW] = mhi; end
      end
      1: begin
        if (ulo) begin mlo_rd_req[i] = val; mlo_wmask[i*FW +: FW] = mlo; end
        if (uhi) mhi_rd_req[i] = val;
      end
      2: begin als_wr_req[i] = val; als_wdata[i*FW +: FW] = dlo; als_wmask[i*FW +: FW] = mlo; end
      default: als_rd_req[i] = val;
    endcase
  endtask

  function automatic bit ack_of(input int i, input int kind, input bit ulo);
    case (kind)
      0: return ulo ? lo_wr_ack[i] : hi_wr_ack[i];
      1: return ulo ? lo_rd_ack[i] : hi_rd_ack[i];
      2: return lo_wr_ack[i];
      default: return lo_rd_ack[i];
    endcase
  endfunction

  task automatic wait_ack(input int i, input int kind, input bit ulo, output int edges);
    edges = 0;
    do begin
      @(posedge clk); #2;
      edges++;
    end while (!ack_of(i, kind, ulo) && edges < 30);
  endtask

  task automatic access(input int i, input int kind, input bit ulo, input bit uhi,
                        input logic [15:0] dlo, input logic [15:0] mlo,
                        input logic [15:0] dhi, input logic [15:0] mhi,
                        output int edges, output logic [3:0] acks, output logic [3:0] errs);
    @(negedge clk);
    set_req(i, kind, ulo, uhi, 1'b1, dlo, mlo, dhi, mhi);
    wait_ack(i, kind, ulo, edges);
    acks = {lo_wr_ack[i], hi_wr_ack[i], lo_rd_ack[i], hi_rd_ack[i]};
    errs = {lo_wr_err[i], hi_wr_err[i], lo_rd_err[i], hi_rd_err[i]};
    @(negedge clk);
    set_req(i, kind, ulo, uhi, 1'b0, dlo, mlo, dhi, mhi);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int e0, e1;
    logic [3:0] a0, r0, a1, r1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9 acks after reset", {16'd0, lo_wr_ack, lo_rd_ack, hi_wr_ack, hi_rd_ack}, 32'd0);
    check("R9 errs after reset", {16'd0, lo_wr_err, lo_rd_err, hi_wr_err, hi_rd_err}, 32'd0);
    check("R9 lo data after reset", lo_rdata[31:0], 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R4: full-mask write on both fields, no extra latency
    access(0, 0, 1, 1, 16'h1234, 16'hFFFF, 16'hABCD, 16'hFFFF, e0, a0, r0);
    check("R1 latency 0", e0, 1);
    check("R4 full write inst0", {lo_rdata[15:0], hi_rdata[15:0]}, 32'h1234ABCD);

    // R4: byte-lane masks
    access(0, 0, 1, 1, 16'hFFFF, 16'hFF00, 16'h0000, 16'h00FF, e0, a0, r0);
    check("R4 lane mask inst0", {lo_rdata[15:0], hi_rdata[15:0]}, 32'hFF34AB00);

    // R1: latency 2 read
    lat_cfg = 2'd2;
    access(1, 1, 1, 1, 16'h0, 16'h0, 16'h0, 16'h0, e0, a0, r0);
    check("R1 latency 2", e0, 3);
    check("R6 read both acks", {28'd0, a0}, 32'h3);

    // R4: low field only, latency 3
    lat_cfg = 2'd3;
    access(2, 0, 1, 0, 16'h5A5A, 16'hFFFF, 16'h0, 16'h0, e0, a0, r0);
    check("R1 latency 3", e0, 4);
    check("R4 low only inst2", {lo_rdata[47:32], hi_rdata[47:32]}, 32'h5A5A0000);
    check("R4 high ack absent", {28'd0, a0}, 32'h8);

    // R5 / R3: errored write
    lat_cfg = 2'd1;
    err_en = 4'b1000;
    access(3, 0, 1, 1, 16'h7777, 16'hFFFF, 16'h7777, 16'hFFFF, e0, a0, r0);
    check("R3 error with ack", {28'd0, r0}, 32'hC);
    check("R5 errored write kept", {lo_rdata[63:48], hi_rdata[63:48]}, 32'h0);
    err_en = 4'b0000;

    // R7: alias write and read
    access(1, 2, 1, 1, 16'hC3C3, 16'hFF00, 16'h0, 16'h0, e0, a0, r0);
    check("R7 alias write both acks", {28'd0, a0}, 32'hC);
    check("R7 alias write low only", {lo_rdata[31:16], hi_rdata[31:16]}, 32'hC3000000);
    access(0, 3, 1, 1, 16'h0, 16'h0, 16'h0, 16'h0, e0, a0, r0);
    check("R7 alias read both acks", {28'd0, a0}, 32'h3);
    check("R7 alias read data", {16'd0, lo_rdata[15:0]}, 32'hFF34);

    // R8: simultaneous main and alias writes
    @(negedge clk);
    set_req(2, 0, 1, 0, 1'b1, 16'h1111, 16'hFFFF, 16'h0, 16'h0);
    set_req(2, 2, 1, 1, 1'b1, 16'h2222, 16'h00FF, 16'h0, 16'h0);
    wait_ack(2, 0, 1, e0);
    check("R8 main first", {16'd0, lo_rdata[47:32]}, 32'h1111);
    @(negedge clk);
    set_req(2, 0, 1, 0, 1'b0, 16'h1111, 16'hFFFF, 16'h0, 16'h0);
    wait_ack(2, 2, 1, e1);
    check("R8 alias after", {16'd0, lo_rdata[47:32]}, 32'h1122);
    check("R8 alias deferred", (e1 >= 2) ? 1 : 0, 1);
    @(negedge clk);
    set_req(2, 2, 1, 1, 1'b0, 16'h2222, 16'h00FF, 16'h0, 16'h0);
    @(negedge clk);

    // R10: two instances at once
    fork
      access(0, 0, 1, 0, 16'h0F0F, 16'hFFFF, 16'h0, 16'h0, e0, a0, r0);
      access(3, 1, 1, 1, 16'h0, 16'h0, 16'h0, 16'h0, e1, a1, r1);
    join
    check("R10 inst0 written", {16'd0, lo_rdata[15:0]}, 32'h0F0F);
    check("R10 inst3 untouched", {lo_rdata[63:48], hi_rdata[63:48]}, 32'h0);
    check("R10 inst3 read acked", {28'd0, a1}, 32'h3);

    // R11: request dropped before ack
    lat_cfg = 2'd3;
    @(negedge clk);
    set_req(1, 0, 0, 1, 1'b1, 16'h0, 16'h0, 16'hEEEE, 16'hFFFF);
    @(negedge clk);
    set_req(1, 0, 0, 1, 1'b0, 16'h0, 16'h0, 16'hEEEE, 16'hFFFF);
    repeat (6) @(negedge clk);
    check("R11 no write on abort", {16'd0, hi_rdata[31:16]}, 32'h0);
    check("R11 no ack on abort", {31'd0, hi_wr_ack[1]}, 32'h0);

    // R6: read with zero mask still returns full field
    lat_cfg = 2'd0;
    access(2, 1, 1, 0, 16'h0, 16'h0000, 16'h0, 16'h0, e0, a0, r0);
    check("R6 read ignores mask", {16'd0, lo_rdata[47:32]}, 32'h1122);

    // R9: reset clears stored fields
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 fields cleared", lo_rdata[31:0] | hi_rdata[31:0] | lo_rdata[63:32], 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule